// File: doc/BRIEF.md
# Channel Booking Control/Status Register

This block holds the 16-bit control/status word of one motion channel, together with a 16-bit interrupt mask. Software that shares a channel uses a read-based booking handshake. The first read of the status word finds the channel free. The trailing edge of that same read marks the channel as taken, so every later reader sees it as in use. The owner gives the channel back by writing a 1 to bit 0.

The word also carries four writable control bits (manual, run, go and interrupt enable). It shows the synchronized home limit, full-travel limit and drive fault inputs as read-only status. It has seven constant bits that writes cannot change. A registered interrupt request goes high when the enable bit is set and any bit of the status word lines up with a set mask bit.

The register port is a plain strobe interface. `rd_stb` is held high for the length of a read access, and `reg_sel` picks the status word (0) or the mask (1). `wr_stb` writes `wr_data` into the selected register. `rd_data` is registered: it is loaded on every clock edge where `rd_stb` is high, and it holds its value otherwise.

Top module: `chan_book_csr`

## Requirements
- R1: After reset, the status word reads 0x401C when both limit inputs and the dead-stop input are 0 and `drive_ok` is 1. The mask reads 0x0000 and `irq` is 0.
- R2: Bit 4 (ready) always reads as the inverse of bit 0 (busy).
- R3: A status-word read returns busy=0 and ready=1 while the channel is free. The falling edge of `rd_stb` at the end of that read sets busy, so every later status read returns busy=1 and ready=0.
- R4: A status-word write with bit 0 = 1 clears busy. A write with bit 0 = 0 leaves busy unchanged.
- R5: Bits 15, 6, 5 and 1 always read 0, and bits 14, 3 and 2 always read 1, whatever value is written.
- R6: Bits 13 (manual), 12 (run), 11 (go) and 7 (interrupt enable) hold the value last written to them through the status word.
- R7: Bit 8 reads 1 only when `home_open` and `deadstop_open` are both 1. Bit 9 reads 1 only when `full_open` and `deadstop_open` are both 1. Both bits are read-only.
- R8: Bit 10 reads 1 when `drive_ok` is 0, and it is read-only.
- R9: With `reg_sel`=1, all 16 bits of the mask register can be written and read back.
- R10: `irq` is 1 exactly when bit 7 is set and (status word AND mask) is nonzero. It follows a change of that condition one clock edge later.
- R11: A read of the mask register never sets busy.
- R12: If a release write arrives on the same clock edge as the booking read's falling edge, the release wins and busy ends up 0.
- R13: Status inputs pass through a two-stage synchronizer, so a change shows in the status word within four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read access in progress; its falling edge ends the read |
| wr_stb | input | 1 | Write strobe, one cycle |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the mask |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| home_open | input | 1 | Home limit switch open or hit |
| full_open | input | 1 | Full-travel limit switch open or hit |
| deadstop_open | input | 1 | Outer dead-stop limit open |
| drive_ok | input | 1 | Drive fault output, 1 means healthy |
| irq | output | 1 | Channel interrupt request |

## Verification
The assertions watch several properties on every cycle. The constant bits and the ready/busy inversion are checked on each status read. Busy may only rise after a falling read strobe and only fall after a release write. A release on the same edge as a booking must win. The interrupt request may only be high when the enable bit was set. The bench scenarios cover what needs a history of accesses. These are the first read returning free while the next read returns booked, mask reads not booking, the limit gating by the dead-stop input, fault polarity, and the interrupt following the mask and the enable bit.

// File: rtl/chanbook_pkg.sv
package chanbook_pkg;
  localparam int CSR_W   = 16;
  localparam int B_BUSY  = 0;
  localparam int B_RDY   = 4;
  localparam int B_INTEN = 7;
  localparam int B_HOME  = 8;
  localparam int B_FULL  = 9;
  localparam int B_FLT   = 10;
  localparam int B_GO    = 11;
  localparam int B_RUN   = 12;
  localparam int B_MAN   = 13;
  // constant bits: which positions are fixed, and their values
  localparam logic [CSR_W-1:0] FIXED_MASK = 16'hC06E;
  localparam logic [CSR_W-1:0] FIXED_ONES = 16'h400C;

  typedef enum logic {SEL_CSR = 1'b0, SEL_MASK = 1'b1} sel_e;

  typedef struct packed {
    logic man;
    logic run;
    logic go;
    logic inten;
  } ctrl_t;
endpackage

// File: rtl/chb_sync.sv
module chb_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chb_booking.sv
module chb_booking (
  input  logic clk,
  input  logic rst,
  input  logic rd_stb,
  input  logic rd_csr,
  input  logic release_req,
  output logic busy
);
  logic rd_q;
  logic rd_csr_q;
  logic rd_fall;

  assign rd_fall = rd_q & ~rd_stb & rd_csr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b0;
      rd_csr_q <= 1'b0;
      busy     <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      if (rd_stb) rd_csr_q <= rd_csr;
      if (release_req)  busy <= 1'b0;
      else if (rd_fall) busy <= 1'b1;
    end
  end

  // R3: booking only follows a falling read strobe
  assert_book_after_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!$past(rd_stb) && $past(rd_stb, 2)));

  // R4: release only by a release write
  assert_release_by_write_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(release_req));

  // R12: release wins over a simultaneous booking
  assert_release_wins_R12: assert property (@(posedge clk) disable iff (rst)
    release_req |=> !busy);
endmodule

// File: rtl/chb_irq.sv
module chb_irq
  import chanbook_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [CSR_W-1:0] wr_data,
  input  logic [CSR_W-1:0] csr_view,
  input  logic             inten,
  output logic [CSR_W-1:0] mask,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      if (mask_we) mask <= wr_data;
      irq <= inten & (|(csr_view & mask));
    end
  end

  // R10: request only with the enable bit set one edge earlier
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(inten));
endmodule

// File: rtl/chan_book_csr.sv
module chan_book_csr
  import chanbook_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic             reg_sel,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  input  logic             home_open,
  input  logic             full_open,
  input  logic             deadstop_open,
  input  logic             drive_ok,
  output logic             irq
);
  localparam int NSTAT = 4;

  logic [NSTAT-1:0] st_q;
  logic             busy;
  ctrl_t            ctrl;
  logic [CSR_W-1:0] csr_view;
  logic [CSR_W-1:0] mask;
  logic             csr_we;
  logic             home_b, full_b, flt_b;

  assign csr_we = wr_stb & (sel_e'(reg_sel) == SEL_CSR);

  // order: {drive_ok, deadstop_open, full_open, home_open}
  chb_sync #(.WIDTH(NSTAT), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({drive_ok, deadstop_open, full_open, home_open}),
    .q   (st_q)
  );

  assign home_b = st_q[0] & st_q[2];
  assign full_b = st_q[1] & st_q[2];
  assign flt_b  = ~st_q[3];

  chb_booking u_book (
    .clk         (clk),
    .rst         (rst),
    .rd_stb      (rd_stb),
    .rd_csr      (sel_e'(reg_sel) == SEL_CSR),
    .release_req (csr_we & wr_data[B_BUSY]),
    .busy        (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (csr_we) begin
      ctrl.man   <= wr_data[B_MAN];
      ctrl.run   <= wr_data[B_RUN];
      ctrl.go    <= wr_data[B_GO];
      ctrl.inten <= wr_data[B_INTEN];
    end
  end

  always_comb begin
    csr_view          = FIXED_ONES;
    csr_view[B_BUSY]  = busy;
    csr_view[B_RDY]   = ~busy;
    csr_view[B_INTEN] = ctrl.inten;
    csr_view[B_HOME]  = home_b;
    csr_view[B_FULL]  = full_b;
    csr_view[B_FLT]   = flt_b;
    csr_view[B_GO]    = ctrl.go;
    csr_view[B_RUN]   = ctrl.run;
    csr_view[B_MAN]   = ctrl.man;
  end

  chb_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .mask_we  (wr_stb & (sel_e'(reg_sel) == SEL_MASK)),
    .wr_data  (wr_data),
    .csr_view (csr_view),
    .inten    (ctrl.inten),
    .mask     (mask),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= (sel_e'(reg_sel) == SEL_MASK) ? mask : csr_view;
  end

  // R5: constant bits seen at the port after every status read
  assert_fixed_bits_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rd_stb && reg_sel == 1'b0) |-> ((rd_data & FIXED_MASK) == FIXED_ONES));

  // R2: ready and busy opposite at the port
  assert_rdy_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_stb && reg_sel == 1'b0) |-> (rd_data[B_RDY] != rd_data[B_BUSY]));
endmodule

// File: tb/chan_book_csr_tb_top.sv
`timescale 1ns/1ps
module chan_book_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_stb = 1'b0, wr_stb = 1'b0, reg_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        home_open = 1'b0, full_open = 1'b0, deadstop_open = 1'b0, drive_ok = 1'b1;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model of the register state
  logic m_busy = 1'b0, m_man = 1'b0, m_run = 1'b0, m_go = 1'b0, m_inten = 1'b0;
  logic [15:0] m_mask = '0;

  logic [15:0] exp_q [$];
  string       req_q [$];
  event        sample_ev;

  always #4 clk = ~clk;

  chan_book_csr dut_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .home_open(home_open), .full_open(full_open),
    .deadstop_open(deadstop_open), .drive_ok(drive_ok), .irq(irq)
  );

  function automatic logic [15:0] model_csr();
    logic [15:0] v;
    v = 16'h400C;
    v[0]  = m_busy;
    v[4]  = ~m_busy;
    v[7]  = m_inten;
    v[8]  = home_open & deadstop_open;
    v[9]  = full_open & deadstop_open;
    v[10] = ~drive_ok;
    v[11] = m_go;
    v[12] = m_run;
    v[13] = m_man;
    return v;
  endfunction

  function automatic logic model_irq();
    return m_inten & (|(model_csr() & m_mask));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares
  always @(sample_ev) begin
    logic [15:0] e;
    string r;
    e = exp_q.pop_front();
    r = req_q.pop_front();
    check(r, rd_data, e);
  end

  task automatic do_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_stb = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    if (sel) m_mask = d;
    else begin
      m_man = d[13]; m_run = d[12]; m_go = d[11]; m_inten = d[7];
      if (d[0]) m_busy = 1'b0;
    end
  endtask

  task automatic do_read(input logic sel, input string req);
    @(negedge clk);
    rd_stb = 1'b1; reg_sel = sel;
    exp_q.push_back(sel ? m_mask : model_csr());
    req_q.push_back(req);
    @(negedge clk);
    -> sample_ev;
    rd_stb = 1'b0;
    if (!sel) m_busy = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_irq(input string req);
    settle();
    check(req, {15'd0, irq}, {15'd0, model_irq()});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();
    check("R1 irq", {15'd0, irq}, 16'd0);
    do_read(1'b1, "R1 mask");
    do_read(1'b0, "R1 R3 first read free");
    do_read(1'b0, "R3 R2 booked");
    do_write(1'b0, 16'h0000);
    do_read(1'b0, "R4 zero write keeps busy");
    do_write(1'b0, 16'h0001);
    do_read(1'b0, "R4 released");
    do_write(1'b0, 16'hFFFE);
    do_read(1'b0, "R5 R6 all ones written");
    do_write(1'b0, 16'h2801);
    do_read(1'b0, "R6 man go");
    do_write(1'b0, 16'h1001);
    do_read(1'b0, "R6 run");
    @(negedge clk); home_open = 1'b1; settle();
    do_read(1'b0, "R7 home without deadstop");
    @(negedge clk); deadstop_open = 1'b1; settle();
    do_read(1'b0, "R7 R13 home with deadstop");
    @(negedge clk); full_open = 1'b1; home_open = 1'b0; settle();
    do_read(1'b0, "R7 full");
    @(negedge clk); drive_ok = 1'b0; settle();
    do_read(1'b0, "R8 fault");
    do_write(1'b1, 16'hA5C3);
    do_read(1'b1, "R9 mask A5C3");
    do_write(1'b1, 16'h0400);
    do_read(1'b1, "R9 mask 0400");
    check_irq("R10 fault no enable");
    do_write(1'b0, 16'h0081);
    check_irq("R10 fault with enable");
    @(negedge clk); drive_ok = 1'b1;
    check_irq("R10 fault cleared");
    do_write(1'b0, 16'h0001);
    do_read(1'b1, "R11 mask read 1");
    do_read(1'b1, "R11 mask read 2");
    do_read(1'b0, "R11 still free");
    do_write(1'b0, 16'h0001);
    // R12: release on the same edge as the booking fall
    @(negedge clk);
    rd_stb = 1'b1; reg_sel = 1'b0;
    exp_q.push_back(model_csr()); req_q.push_back("R12 read before collision");
    @(negedge clk);
    -> sample_ev;
    rd_stb = 1'b0; wr_stb = 1'b1; wr_data = 16'h0001;
    @(negedge clk);
    wr_stb = 1'b0;
    m_busy = 1'b0; m_man = 1'b0; m_run = 1'b0; m_go = 1'b0; m_inten = 1'b0;
    do_read(1'b0, "R12 release wins");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule